// File: doc/BRIEF.md
# Serial Flash Image Programmer and Reader

This block copies a whole image from a local byte buffer into an attached serial flash. It can also copy the whole flash back into that buffer. It never drives the flash pins itself. Every flash operation goes to a command engine as one request. The request carries up to five outgoing bytes and asks for up to three returned bytes. The engine raises an acknowledge when the transfer is over.

A program run first reads the flash status byte. If any protection bit is set, it writes the status back with those bits cleared. It then stores the image one byte at a time, sending a write-enable before each byte. After each byte it waits a fixed settle time. A readback run fetches the flash contents in chunks of three bytes. The last chunk is shortened to the bytes that remain. Each fetched byte is written into the buffer in address order.

For the whole of either run, the command engine is held in its slow-clock setting. The setting is released when the run ends.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `eng_req_o`, `buf_we_o`, `done_o`, `progress_o` and `eng_slow_o` are all 0.
- R2: A program run (`start_i` with `readback_i`=0) issues status-read opcode 0x05 as its first request, with `eng_wlen_o`=1 and `eng_rlen_o`=1. The status byte is taken from `eng_rdata_i[23:16]`.
- R3: If status bits 5..2 (mask 0x3C) are not all zero, a write-enable (0x06) follows, then a write-status request (opcode 0x01, length 2). Its second byte equals the status with only bits 5..2 cleared. If those bits are all zero, no write-status is sent.
- R4: Each flash address from 0 to MEM_BYTES-1 is programmed once, in ascending order. Each byte-program request is preceded directly by a write-enable (0x06). A byte-program request has opcode 0x02, length 5, a 24-bit address sent most significant byte first, and then the buffer byte at that address.
- R5: After a byte-program request is acknowledged, no request is raised for at least GAP_CYCLES clock cycles.
- R6: A readback run (`start_i` with `readback_i`=1) sends read requests (opcode 0x03, length 4, 24-bit address MSB first) at addresses 0, 3, 6, and so on. Each read asks for 3 bytes, except the last, which asks for exactly MEM_BYTES minus its address.
- R7: The bytes of each read are written to the buffer one per cycle through `buf_we_o`, at consecutive addresses starting at the read address. The byte in `eng_rdata_i[23:16]` goes first.
- R8: `eng_slow_o` is 1 whenever a request is raised and throughout a run. It returns to 0 when the run completes.
- R9: A raised request keeps `eng_req_o`, `eng_wdata_o`, `eng_wlen_o` and `eng_rlen_o` unchanged until the cycle in which `eng_ack_i` is 1. Outgoing byte k sits in `eng_wdata_o[39-8k -: 8]`.
- R10: `progress_o` pulses for one cycle after every PROGRESS_BYTES-th byte-program acknowledge of a run.
- R11: `done_o` pulses for one cycle when a run completes. A `start_i` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (accepted only when idle) |
| readback_i | input | 1 | Run type: 0 = program, 1 = readback |
| done_o | output | 1 | One-cycle completion pulse |
| progress_o | output | 1 | One-cycle pulse per PROGRESS_BYTES bytes programmed |
| buf_addr_o | output | AW | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data for `buf_addr_o` (combinational) |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| eng_slow_o | output | 1 | Select the slow serial clock in the command engine |
| eng_req_o | output | 1 | Command request |
| eng_ack_i | input | 1 | Command acknowledge, one cycle |
| eng_wlen_o | output | 3 | Number of outgoing bytes (1..5) |
| eng_wdata_o | output | 40 | Outgoing bytes, first byte in bits 39:32 |
| eng_rlen_o | output | 2 | Number of bytes to return (0..3) |
| eng_rdata_i | input | 24 | Returned bytes, first byte in bits 23:16 |

## Verification
Two situations are hard to reach from the ports.

The first is the final shortened read chunk, together with the stop in the middle of that chunk. It is reached by choosing a flash size that is not a multiple of three, so every readback ends on a partial chunk.

The second is the unprotect branch, whose write-status value must keep the bits outside the protection mask. The bench model loads a status byte with protection bits mixed with other set bits. It runs program passes with a clear status, a fully set status and random status values.

The settle gap after each byte depends on acknowledge timing. The model therefore acknowledges with random latency, so the gap is measured under varying arrival times.

// File: rtl/flash_prog_pkg.sv
`timescale 1ns/1ps
package flash_prog_pkg;

  typedef enum logic [2:0] {
    OP_RDSR,
    OP_WREN,
    OP_WRSR,
    OP_PROG,
    OP_READ
  } flash_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDSR,
    S_WEN_SR,
    S_WRSR,
    S_WEN,
    S_PROG,
    S_GAP,
    S_READ,
    S_STORE
  } seq_state_e;

  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] PROT_MASK = 8'h3C;

endpackage

// File: rtl/fps_cmd_fmt.sv
`timescale 1ns/1ps
// Builds the outgoing byte frame for one command-engine request.
module fps_cmd_fmt
  import flash_prog_pkg::*;
(
  input  flash_op_e   op_i,
  input  logic [23:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic [7:0]  stat_i,
  output logic [2:0]  wlen_o,
  output logic [39:0] frame_o
);

  always_comb begin
    wlen_o  = 3'd1;
    frame_o = '0;
    unique case (op_i)
      OP_RDSR: begin
        wlen_o  = 3'd1;
        frame_o = {OPC_RDSR, 32'h0};
      end
      OP_WREN: begin
        wlen_o  = 3'd1;
        frame_o = {OPC_WREN, 32'h0};
      end
      OP_WRSR: begin
        wlen_o  = 3'd2;
        frame_o = {OPC_WRSR, stat_i & ~PROT_MASK, 24'h0};
      end
      OP_PROG: begin
        wlen_o  = 3'd5;
        frame_o = {OPC_PROG, addr_i, data_i};
      end
      default: begin
        wlen_o  = 3'd4;
        frame_o = {OPC_READ, addr_i, 8'h0};
      end
    endcase
  end

endmodule

// File: rtl/fps_delay.sv
`timescale 1ns/1ps
// Settle timer: load starts a countdown of GAP_CYCLES, expired when zero.
module fps_delay #(
  parameter int GAP_CYCLES = 2500,
  localparam int CW = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = CW'(GAP_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/flash_prog_seq.sv
`timescale 1ns/1ps
// Whole-flash program / readback sequencer driving a small command engine.
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int MEM_BYTES      = 2048,
  parameter int PROGRESS_BYTES = 1024,
  parameter int GAP_CYCLES     = 2500,
  localparam int AW = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          readback_i,
  output logic          done_o,
  output logic          progress_o,
  output logic [AW-1:0] buf_addr_o,
  input  logic [7:0]    buf_rdata_i,
  output logic          buf_we_o,
  output logic [7:0]    buf_wdata_o,
  output logic          eng_slow_o,
  output logic          eng_req_o,
  input  logic          eng_ack_i,
  output logic [2:0]    eng_wlen_o,
  output logic [39:0]   eng_wdata_o,
  output logic [1:0]    eng_rlen_o,
  input  logic [23:0]   eng_rdata_i
);

  localparam int PW = $clog2(MEM_BYTES + 1) + 1;
  localparam int GW = (PROGRESS_BYTES > 1) ? $clog2(PROGRESS_BYTES) : 1;
  localparam logic [PW-1:0] END_POS  = PW'(MEM_BYTES);
  localparam logic [PW-1:0] LAST_POS = PW'(MEM_BYTES - 1);
  localparam logic [GW-1:0] PROG_WRAP = GW'(PROGRESS_BYTES - 1);

  seq_state_e    st_q, st_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [7:0]    stat_q, stat_d;
  logic [23:0]   rbuf_q, rbuf_d;
  logic [1:0]    rcnt_q, rcnt_d;
  logic [1:0]    ridx_q, ridx_d;
  logic [GW-1:0] pcnt_q, pcnt_d;
  logic          done_q, done_d;
  logic          prog_q, prog_d;
  logic          gap_load, gap_expired;
  flash_op_e     op;
  logic [PW-1:0] remain;
  logic [1:0]    chunk;

  // Length of the current read chunk: three, or what is left at the end.
  assign remain = END_POS - pos_q;
  assign chunk  = (remain >= PW'(3)) ? 2'd3 : remain[1:0];

  always_comb begin
    unique case (st_q)
      S_RDSR:         op = OP_RDSR;
      S_WEN_SR, S_WEN: op = OP_WREN;
      S_WRSR:         op = OP_WRSR;
      S_PROG:         op = OP_PROG;
      default:        op = OP_READ;
    endcase
  end

  fps_cmd_fmt u_fmt (
    .op_i   (op),
    .addr_i (24'(pos_q)),
    .data_i (buf_rdata_i),
    .stat_i (stat_q),
    .wlen_o (eng_wlen_o),
    .frame_o(eng_wdata_o)
  );

  fps_delay #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (gap_load),
    .expired_o(gap_expired)
  );

  assign eng_req_o  = (st_q == S_RDSR) || (st_q == S_WEN_SR) || (st_q == S_WRSR) ||
                      (st_q == S_WEN)  || (st_q == S_PROG)   || (st_q == S_READ);
  assign eng_rlen_o = (st_q == S_RDSR) ? 2'd1 : (st_q == S_READ) ? chunk : 2'd0;
  assign eng_slow_o = (st_q != S_IDLE);
  assign buf_addr_o = pos_q[AW-1:0];
  assign buf_we_o   = (st_q == S_STORE);
  assign done_o     = done_q;
  assign progress_o = prog_q;

  always_comb begin
    unique case (ridx_q)
      2'd0:    buf_wdata_o = rbuf_q[23:16];
      2'd1:    buf_wdata_o = rbuf_q[15:8];
      default: buf_wdata_o = rbuf_q[7:0];
    endcase
  end

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    pos_d    = pos_q;
    stat_d   = stat_q;
    rbuf_d   = rbuf_q;
    rcnt_d   = rcnt_q;
    ridx_d   = ridx_q;
    pcnt_d   = pcnt_q;
    done_d   = 1'b0;
    prog_d   = 1'b0;
    gap_load = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        pos_d  = '0;
        pcnt_d = '0;
        st_d   = readback_i ? S_READ : S_RDSR;
      end
      S_RDSR: if (eng_ack_i) begin
        stat_d = eng_rdata_i[23:16];
        st_d   = ((eng_rdata_i[23:16] & PROT_MASK) != 8'h0) ? S_WEN_SR : S_WEN;
      end
      S_WEN_SR: if (eng_ack_i) st_d = S_WRSR;
      S_WRSR:   if (eng_ack_i) st_d = S_WEN;
      S_WEN:    if (eng_ack_i) st_d = S_PROG;
      S_PROG: if (eng_ack_i) begin
        gap_load = 1'b1;
        st_d     = S_GAP;
        if (pcnt_q == PROG_WRAP) begin
          pcnt_d = '0;
          prog_d = 1'b1;
        end else begin
          pcnt_d = pcnt_q + GW'(1);
        end
      end
      S_GAP: if (gap_expired) begin
        if (pos_q == LAST_POS) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else begin
          pos_d = pos_q + PW'(1);
          st_d  = S_WEN;
        end
      end
      S_READ: if (eng_ack_i) begin
        rbuf_d = eng_rdata_i;
        rcnt_d = chunk;
        ridx_d = 2'd0;
        st_d   = S_STORE;
      end
      S_STORE: begin
        pos_d  = pos_q + PW'(1);
        ridx_d = ridx_q + 2'd1;
        if (ridx_q == rcnt_q - 2'd1) begin
          if (pos_q == LAST_POS) begin
            done_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            st_d = S_READ;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pos_q  <= '0;
      stat_q <= '0;
      rbuf_q <= '0;
      rcnt_q <= '0;
      ridx_q <= '0;
      pcnt_q <= '0;
      done_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      stat_q <= stat_d;
      rbuf_q <= rbuf_d;
      rcnt_q <= rcnt_d;
      ridx_q <= ridx_d;
      pcnt_q <= pcnt_d;
      done_q <= done_d;
      prog_q <= prog_d;
    end
  end

endmodule

// File: rtl/flash_prog_seq_chk.sv
`timescale 1ns/1ps
module flash_prog_seq_chk #(
  parameter int GAP_CYCLES = 2500,
  localparam int CW = $clog2(GAP_CYCLES + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic        progress_o,
  input logic        buf_we_o,
  input logic        eng_slow_o,
  input logic        eng_req_o,
  input logic        eng_ack_i,
  input logic [2:0]  eng_wlen_o,
  input logic [39:0] eng_wdata_o,
  input logic [1:0]  eng_rlen_o
);

  // Independent count of cycles since the last acknowledged byte program.
  logic [CW-1:0] hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (eng_req_o && eng_ack_i && eng_wdata_o[39:32] == 8'h02)
      hold_cnt <= CW'(GAP_CYCLES);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - CW'(1);
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_slow_o |-> (!eng_req_o && !buf_we_o && !progress_o));

  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |-> !eng_req_o);

  p_read_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && eng_wdata_o[39:32] == 8'h03) |-> (eng_rlen_o != 2'd0 && eng_wlen_o == 3'd4));

  p_store_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> !eng_req_o);

  p_req_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_o |-> eng_slow_o);

  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_o && !eng_ack_i) |=> (eng_req_o && $stable(eng_wdata_o) &&
                                    $stable(eng_wlen_o) && $stable(eng_rlen_o)));

  p_progress_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    progress_o |=> !progress_o);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_o     (done_o),
  .progress_o (progress_o),
  .buf_we_o   (buf_we_o),
  .eng_slow_o (eng_slow_o),
  .eng_req_o  (eng_req_o),
  .eng_ack_i  (eng_ack_i),
  .eng_wlen_o (eng_wlen_o),
  .eng_wdata_o(eng_wdata_o),
  .eng_rlen_o (eng_rlen_o)
);

// File: tb/tb_flash_prog_seq.sv
`timescale 1ns/1ps
module tb_flash_prog_seq;

  localparam int MEM   = 20;   // not a multiple of 3: last read chunk is short
  localparam int PSTEP = 8;
  localparam int GAP   = 6;
  localparam int AW    = $clog2(MEM);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, readback;
  logic          done, progress, buf_we, eng_slow, eng_req, eng_ack;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_rdata, buf_wdata;
  logic [2:0]    eng_wlen;
  logic [39:0]   eng_wdata;
  logic [1:0]    eng_rlen;
  logic [23:0]   eng_rdata;

  flash_prog_seq #(.MEM_BYTES(MEM), .PROGRESS_BYTES(PSTEP), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .readback_i(readback),
    .done_o(done), .progress_o(progress), .buf_addr_o(buf_addr),
    .buf_rdata_i(buf_rdata), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .eng_slow_o(eng_slow), .eng_req_o(eng_req), .eng_ack_i(eng_ack),
    .eng_wlen_o(eng_wlen), .eng_wdata_o(eng_wdata), .eng_rlen_o(eng_rlen),
    .eng_rdata_i(eng_rdata)
  );

  logic [7:0] bmem [MEM];
  logic [7:0] fmem [MEM];
  assign buf_rdata = bmem[buf_addr];

  int checks = 0, fails = 0;
  int cyc = 0;
  int last_prog_cyc = -1000;
  int exp_paddr, exp_raddr, cmd_idx, wrsr_cnt, progress_cnt, done_cnt, lat;
  bit in_prog_run, wel, last_wren, finished;
  logic [7:0] fstat, init_stat;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected read length for a chunk starting at address a.
  function automatic int exp_chunk(input int a);
    return (MEM - a >= 3) ? 3 : MEM - a;
  endfunction

  // Flash / command-engine model
  task automatic serve();
    logic [7:0] op;
    int a;
    logic [23:0] r;
    op = eng_wdata[39:32];
    chk(eng_slow, "R8 slow during request", eng_slow, 1);
    chk(cyc - last_prog_cyc > GAP, "R5 settle gap", cyc - last_prog_cyc, GAP + 1);
    case (op)
      8'h05: begin
        chk(in_prog_run && cmd_idx == 0, "R2 status read first", cmd_idx, 0);
        chk(eng_wlen == 3'd1 && eng_rlen == 2'd1, "R2 status lengths", {eng_wlen, eng_rlen}, 5'b00101);
        eng_rdata <= {fstat, 16'h0};
      end
      8'h06: wel = 1'b1;
      8'h01: begin
        chk(last_wren && eng_wlen == 3'd2, "R3 write-status framing", {last_wren, eng_wlen}, 4'b1010);
        chk(eng_wdata[31:24] == (init_stat & ~8'h3C), "R3 write-status value",
            eng_wdata[31:24], init_stat & ~8'h3C);
        fstat = eng_wdata[31:24];
        wrsr_cnt++;
        wel = 1'b0;
      end
      8'h02: begin
        a = int'(eng_wdata[31:8]);
        chk(last_wren && eng_wlen == 3'd5, "R4 write-enable before program", {last_wren, eng_wlen}, 4'b1101);
        chk(a == exp_paddr, "R4 program address order", a, exp_paddr);
        if (a < MEM) begin
          chk(eng_wdata[7:0] == bmem[a], "R4 program data", eng_wdata[7:0], bmem[a]);
          fmem[a] = eng_wdata[7:0];
        end
        exp_paddr++;
        wel = 1'b0;
        last_prog_cyc = cyc;
      end
      8'h03: begin
        a = int'(eng_wdata[31:8]);
        chk(!in_prog_run, "R11 no read during program run", in_prog_run, 0);
        chk(a == exp_raddr, "R6 read address step", a, exp_raddr);
        chk(eng_wlen == 3'd4 && int'(eng_rlen) == exp_chunk(a), "R6 read lengths",
            {eng_wlen, eng_rlen}, {3'd4, 2'(exp_chunk(a))});
        for (int i = 0; i < 3; i++)
          r[23-8*i -: 8] = (a + i < MEM) ? fmem[a+i] : 8'hEE;
        eng_rdata <= r;
        exp_raddr += 3;
      end
      default: chk(1'b0, "R9 unknown opcode", op, 0);
    endcase
    last_wren = (op == 8'h06);
    cmd_idx++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_ack <= 1'b0;
    end else begin
      if (buf_we) bmem[buf_addr] <= buf_wdata;
      if (progress) begin
        progress_cnt++;
        chk(exp_paddr % PSTEP == 0 && exp_paddr != 0, "R10 progress position", exp_paddr, PSTEP);
      end
      if (done) done_cnt++;
      if (eng_ack) eng_ack <= 1'b0;
      else if (eng_req) begin
        if (lat > 0) lat--;
        else begin
          lat = int'($urandom % 3);
          serve();
          eng_ack <= 1'b1;
        end
      end
    end
  end

  task automatic wait_done(input string tag);
    int n = 0;
    while (done_cnt == 0 && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
    chk(done_cnt > 0, tag, done_cnt, 1);
    repeat (3) @(posedge clk);
    #1;
    chk(done_cnt == 1, "R11 done single pulse", done_cnt, 1);
    chk(!eng_slow, "R8 slow released after run", eng_slow, 0);
  endtask

  task automatic pulse_start(input bit rb);
    start = 1'b1; readback = rb;
    @(posedge clk); #1;
    start = 1'b0; readback = 1'b0;
  endtask

  task automatic run_prog(input logic [7:0] st, input bit poke);
    int bad = 0;
    for (int i = 0; i < MEM; i++) begin
      bmem[i] = 8'($urandom);
      fmem[i] = 8'hFF;
    end
    fstat = st; init_stat = st;
    exp_paddr = 0; cmd_idx = 0; wrsr_cnt = 0; progress_cnt = 0; done_cnt = 0;
    wel = 0; last_wren = 0; in_prog_run = 1;
    pulse_start(1'b0);
    if (poke) begin
      repeat (40) @(posedge clk);
      #1;
      pulse_start(1'b1);  // must be ignored (R11)
    end
    wait_done("R11 program run completes");
    for (int i = 0; i < MEM; i++) if (fmem[i] != bmem[i]) bad++;
    chk(bad == 0, "R4 flash image equals buffer", bad, 0);
    chk(exp_paddr == MEM, "R4 every address programmed", exp_paddr, MEM);
    chk(wrsr_cnt == (((st & 8'h3C) != 0) ? 1 : 0), "R3 unprotect only when needed",
        wrsr_cnt, ((st & 8'h3C) != 0) ? 1 : 0);
    chk(progress_cnt == MEM / PSTEP, "R10 progress count", progress_cnt, MEM / PSTEP);
    in_prog_run = 0;
  endtask

  task automatic run_read();
    int bad = 0;
    logic [7:0] img [MEM];
    for (int i = 0; i < MEM; i++) begin
      img[i] = 8'($urandom);
      fmem[i] = img[i];
      bmem[i] = ~img[i];
    end
    exp_raddr = 0; cmd_idx = 0; done_cnt = 0; in_prog_run = 0;
    pulse_start(1'b1);
    wait_done("R11 readback run completes");
    for (int i = 0; i < MEM; i++) if (bmem[i] != img[i]) bad++;
    chk(bad == 0, "R7 buffer equals flash", bad, 0);
    chk(exp_raddr == 3 * ((MEM + 2) / 3), "R6 chunk count", exp_raddr / 3, (MEM + 2) / 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; readback = 1'b0; eng_rdata = '0; lat = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(!eng_req && !buf_we && !done && !progress && !eng_slow, "R1 reset quiet",
        {eng_req, buf_we, done, progress, eng_slow}, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!eng_req && !eng_slow && !done, "R1 idle after reset", {eng_req, eng_slow, done}, 0);

    run_prog(8'h00, 1'b0);   // no protection
    run_prog(8'hBF, 1'b1);   // all protection bits + others; mid-run start ignored
    run_read();
    for (int k = 0; k < 3; k++) run_prog(8'($urandom), 1'b0);
    run_read();
    run_read();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule